// File: doc/BRIEF.md
# Programming Command Packet Framer

This block sits behind a serial programming link that delivers 16-bit words one at a time. It reads a header word, whose top nibble names the command and whose low twelve bits give the total packet length in words with the header counted. It then takes in the remaining payload words and either answers the command locally or hands it to a flash backend. For every packet it emits a two-word response: a status word that echoes the command, followed by a length word.

Two commands are answered without the backend. The liveness probe (opcode 0h) always passes. The version query (opcode Bh) returns a configurable version byte, with the major number in the upper nibble and the revision in the lower nibble. Opcodes 4h (erase), 5h (row program) and Dh (single-word program) go to the backend. Their payload words stream out as they arrive, a start pulse follows the last payload word, and the framer then waits for a done strobe that carries a 2-bit error code. Every other opcode is reserved: its payload is skipped and it gets a negative acknowledgement. There is no time-out at any point.

Top module: `pkt_framer`

## Requirements
- R1: While reset is held and in the first cycle after it, tx_valid, be_start and be_wvalid are 0.
- R2: Opcode 0h with length 1 or more answers 1000h and then 0002h on two consecutive cycles. Any payload words are consumed and ignored. With length 1, the first response word appears in the cycle right after the header is taken.
- R3: Opcode Bh with length 1 or more answers {1h, Bh, VERSION} and then 0002h, with no backend activity.
- R4: For backend opcodes (4h needs length 2 or more, 5h needs 3 or more, Dh needs 4 or more), each of the length-1 payload words is presented once, in order, on be_wdata with be_wvalid high. After the last payload word, be_start pulses for exactly one cycle and be_op holds the opcode.
- R5: A backend done strobe with be_err = 0 yields the status word {1h, opcode, 00h} and then 0002h.
- R6: A done strobe with be_err = 1 yields {3h, opcode, 01h}. be_err = 2 or 3 yields {3h, opcode, 02h}. The second word is 0002h in both cases.
- R7: Reserved opcodes (every value other than 0h, 4h, 5h, Bh and Dh) have length-1 payload words skipped. The framer answers {2h, opcode, 00h} and then 0002h, and never asserts be_start or be_wvalid.
- R8: A header whose length is below the minimum for its opcode (1 for opcodes not named in R4) is answered at once with {2h, opcode, 00h} and then 0002h. No payload is consumed: the next word is parsed as a header.
- R9: Words that arrive while the framer waits for the backend or sends a response are dropped. They produce no extra response.
- R10: The framer waits without limit for payload words. Gaps of any length between words do not change the result.
- R11: A done strobe while no backend command is outstanding is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | An incoming link word is present this cycle |
| rx_data | input | 16 | Incoming link word |
| tx_valid | output | 1 | A response word is present this cycle |
| tx_data | output | 16 | Response word |
| be_start | output | 1 | One-cycle request to the backend to run the command |
| be_op | output | 4 | Opcode of the current command |
| be_wvalid | output | 1 | A payload word is forwarded to the backend |
| be_wdata | output | 16 | Forwarded payload word |
| be_done | input | 1 | Backend finished the outstanding command |
| be_err | input | 2 | Backend result code, valid with be_done |

## Verification
A payload counter that slips by one shows up at the ports within one word. The response either arrives a word early or late, or the next header is taken as payload, so the following command answers with the wrong echoed opcode. A wrong command class shows up as soon as the first response word appears: the status nibble is wrong, or the forwarded word stream is missing or present when it should not be. A state machine that takes words while busy shows up as a third response word, or as a spurious second packet, right after the expected pair.

// File: rtl/pktf_pkg.sv
package pktf_pkg;

    localparam int WORD_W = 16;
    localparam int OP_W   = 4;
    localparam int LEN_W  = WORD_W - OP_W;
    localparam int STAT_W = 4;
    localparam int QUAL_W = WORD_W - OP_W - STAT_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OP_W-1:0]   op_t;

    typedef struct packed {
        op_t              op;
        logic [LEN_W-1:0] len;
    } hdr_t;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        op_t               op;
        logic [QUAL_W-1:0] qual;
    } resp_t;

    typedef enum logic [1:0] {CL_PING, CL_VER, CL_BACK, CL_RSVD} op_class_e;
    typedef enum logic [2:0] {S_IDLE, S_DATA, S_ISSUE, S_WAIT, S_RESP0, S_RESP1} state_e;
    typedef enum logic [1:0] {RK_PASS, RK_NACK, RK_BACK} resp_kind_e;

    localparam logic [STAT_W-1:0] STAT_PASS = 4'h1;
    localparam logic [STAT_W-1:0] STAT_NACK = 4'h2;
    localparam logic [STAT_W-1:0] STAT_FAIL = 4'h3;

    localparam op_t OP_PING  = 4'h0;
    localparam op_t OP_ERASE = 4'h4;
    localparam op_t OP_ROW   = 4'h5;
    localparam op_t OP_VER   = 4'hB;
    localparam op_t OP_WORD  = 4'hD;

    localparam word_t RESP_LEN_WORD = 16'h0002;

    function automatic op_class_e classify(input op_t op);
        case (op)
            OP_PING:                  return CL_PING;
            OP_VER:                   return CL_VER;
            OP_ERASE, OP_ROW, OP_WORD: return CL_BACK;
            default:                  return CL_RSVD;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] min_len(input op_t op);
        case (op)
            OP_ERASE: return LEN_W'(2);
            OP_ROW:   return LEN_W'(3);
            OP_WORD:  return LEN_W'(4);
            default:  return LEN_W'(1);
        endcase
    endfunction

    function automatic logic [QUAL_W-1:0] err_qual(input logic [1:0] err);
        case (err)
            2'd0:    return QUAL_W'(0);
            2'd1:    return QUAL_W'(1);
            default: return QUAL_W'(2);
        endcase
    endfunction

    function automatic word_t pack_resp(input logic [STAT_W-1:0] status,
                                        input op_t op,
                                        input logic [QUAL_W-1:0] qual);
        resp_t r;
        r.status = status;
        r.op     = op;
        r.qual   = qual;
        return word_t'(r);
    endfunction

endpackage

// File: rtl/pktf_hdr_decode.sv
module pktf_hdr_decode
    import pktf_pkg::*;
(
    input  word_t            hdr_word,
    output op_t              op,
    output op_class_e        cls,
    output logic             too_short,
    output logic [LEN_W-1:0] extra
);
    hdr_t hdr;

    always_comb begin
        hdr       = hdr_t'(hdr_word);
        op        = hdr.op;
        cls       = classify(hdr.op);
        too_short = hdr.len < min_len(hdr.op);
        extra     = (hdr.len == '0) ? '0 : hdr.len - LEN_W'(1);
    end
endmodule

// File: rtl/pktf_word_count.sv
module pktf_word_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (step && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pktf_resp_gen.sv
module pktf_resp_gen
    import pktf_pkg::*;
#(
    parameter logic [QUAL_W-1:0] VERSION = 8'h23
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  resp_kind_e kind,
    input  op_t        op,
    input  logic [1:0] err,
    output word_t      word
);
    word_t word_q;

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else if (load) begin
            case (kind)
                RK_PASS: word_q <= pack_resp(STAT_PASS, op,
                                             (op == OP_VER) ? VERSION : QUAL_W'(0));
                RK_BACK: word_q <= pack_resp((err == 2'd0) ? STAT_PASS : STAT_FAIL,
                                             op, err_qual(err));
                default: word_q <= pack_resp(STAT_NACK, op, QUAL_W'(0));
            endcase
        end
    end

    assign word = word_q;
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
    import pktf_pkg::*;
#(
    parameter logic [QUAL_W-1:0] VERSION = 8'h23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    output logic              be_start,
    output logic [OP_W-1:0]   be_op,
    output logic              be_wvalid,
    output logic [WORD_W-1:0] be_wdata,
    input  logic              be_done,
    input  logic [1:0]        be_err
);
    state_e           state_q, state_d;
    op_t              op_q, dec_op, resp_op;
    op_class_e        cls_q, dec_cls, fin_cls;
    logic             dec_short;
    logic [LEN_W-1:0] dec_extra;
    logic             cnt_last;
    logic             hdr_take, data_take, finish;
    logic             resp_load;
    resp_kind_e       resp_kind;
    word_t            resp_word;

    pktf_hdr_decode u_dec (
        .hdr_word  (rx_data),
        .op        (dec_op),
        .cls       (dec_cls),
        .too_short (dec_short),
        .extra     (dec_extra)
    );

    pktf_word_count #(.CNT_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (hdr_take),
        .load_val (dec_extra),
        .step     (data_take),
        .last     (cnt_last)
    );

    pktf_resp_gen #(.VERSION(VERSION)) u_resp (
        .clk  (clk),
        .rst  (rst),
        .load (resp_load),
        .kind (resp_kind),
        .op   (resp_op),
        .err  (be_err),
        .word (resp_word)
    );

    always_comb begin
        hdr_take  = (state_q == S_IDLE) && rx_valid;
        data_take = (state_q == S_DATA) && rx_valid;
        finish    = (hdr_take && !dec_short && dec_extra == '0) ||
                    (data_take && cnt_last);
        fin_cls   = hdr_take ? dec_cls : cls_q;
        resp_op   = hdr_take ? dec_op  : op_q;

        state_d   = state_q;
        resp_load = 1'b0;
        resp_kind = RK_NACK;

        case (state_q)
            S_IDLE: begin
                if (hdr_take) begin
                    if (dec_short) begin
                        resp_load = 1'b1;
                        resp_kind = RK_NACK;
                        state_d   = S_RESP0;
                    end else if (dec_extra != '0) begin
                        state_d = S_DATA;
                    end
                end
            end
            S_ISSUE: state_d = S_WAIT;
            S_WAIT: begin
                if (be_done) begin
                    resp_load = 1'b1;
                    resp_kind = RK_BACK;
                    state_d   = S_RESP0;
                end
            end
            S_RESP0: state_d = S_RESP1;
            S_RESP1: state_d = S_IDLE;
            default: ;
        endcase

        if (finish) begin
            case (fin_cls)
                CL_BACK: state_d = S_ISSUE;
                CL_RSVD: begin
                    resp_load = 1'b1;
                    resp_kind = RK_NACK;
                    state_d   = S_RESP0;
                end
                default: begin
                    resp_load = 1'b1;
                    resp_kind = RK_PASS;
                    state_d   = S_RESP0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            op_q    <= '0;
            cls_q   <= CL_PING;
        end else begin
            state_q <= state_d;
            if (hdr_take) begin
                op_q  <= dec_op;
                cls_q <= dec_cls;
            end
        end
    end

    always_comb begin
        tx_valid  = (state_q == S_RESP0) || (state_q == S_RESP1);
        tx_data   = (state_q == S_RESP0) ? resp_word :
                    (state_q == S_RESP1) ? RESP_LEN_WORD : '0;
        be_start  = (state_q == S_ISSUE);
        be_op     = op_q;
        be_wvalid = data_take && (cls_q == CL_BACK);
        be_wdata  = rx_data;
    end
endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk (
    input logic        clk,
    input logic        rst,
    input logic        tx_valid,
    input logic [15:0] tx_data,
    input logic        be_start,
    input logic        be_wvalid
);
    // R4: start request lasts a single cycle
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        be_start |=> !be_start);

    // R2: second response word is always the length word
    p_len_word_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |=> (tx_valid && tx_data == 16'h0002));

    // R5: a response is exactly two words long
    p_pair_end_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && $past(tx_valid)) |=> !tx_valid);

    // R6: status nibble takes only pass, nack or fail codes
    p_status_code_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> (tx_data[15:12] == 4'h1 || tx_data[15:12] == 4'h2 ||
                             tx_data[15:12] == 4'h3));

    // R7: a negative acknowledgement carries a zero qualifier
    p_nack_qual_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_valid) && tx_data[15:12] == 4'h2) |-> (tx_data[7:0] == 8'h00));

    // R2: probe answer is exactly 1000h
    p_ping_word_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_valid) && tx_data[15:8] == 8'h10) |-> (tx_data[7:0] == 8'h00));

    // R9: forwarding never overlaps a response or a start request
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
        be_wvalid |-> (!tx_valid && !be_start));
endmodule

bind pkt_framer pkt_framer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .be_start  (be_start),
    .be_wvalid (be_wvalid)
);

// File: tb/tb_pkt_framer.sv
module tb_pkt_framer;
    localparam logic [7:0] VER = 8'h23;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_data = '0;
    logic        tx_valid;
    logic [15:0] tx_data;
    logic        be_start;
    logic [3:0]  be_op;
    logic        be_wvalid;
    logic [15:0] be_wdata;
    logic        be_done = 1'b0;
    logic [1:0]  be_err = '0;

    int n_chk = 0;
    int n_fail = 0;
    int start_cnt = 0;
    logic [3:0]  start_op;
    logic [15:0] tx_q[$];
    logic [15:0] w_q[$];
    logic [15:0] pl_q[$];

    pkt_framer #(.VERSION(VER)) dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .be_start(be_start),
        .be_op(be_op), .be_wvalid(be_wvalid), .be_wdata(be_wdata),
        .be_done(be_done), .be_err(be_err)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (tx_valid) tx_q.push_back(tx_data);
            if (be_wvalid) w_q.push_back(be_wdata);
            if (be_start) begin
                start_cnt++;
                start_op = be_op;
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int mlen(input logic [3:0] op);
        case (op)
            4'h4: return 2;
            4'h5: return 3;
            4'hD: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic bit is_back(input logic [3:0] op);
        return op == 4'h4 || op == 4'h5 || op == 4'hD;
    endfunction

    function automatic logic [15:0] exp_w0(input logic [3:0] op, input int len, input logic [1:0] err);
        if (len < mlen(op)) return {4'h2, op, 8'h00};
        if (op == 4'h0) return 16'h1000;
        if (op == 4'hB) return {4'h1, 4'hB, VER};
        if (is_back(op)) begin
            if (err == 2'd0) return {4'h1, op, 8'h00};
            if (err == 2'd1) return {4'h3, op, 8'h01};
            return {4'h3, op, 8'h02};
        end
        return {4'h2, op, 8'h00};
    endfunction

    function automatic string tag_of(input logic [3:0] op, input int len, input logic [1:0] err);
        if (len < mlen(op)) return "R8";
        if (op == 4'h0) return "R2";
        if (op == 4'hB) return "R3";
        if (is_back(op)) return (err == 2'd0) ? "R5" : "R6";
        return "R7";
    endfunction

    task automatic send_word(input logic [15:0] w, input int gap);
        rx_valid = 1'b1;
        rx_data  = w;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // runs one command from a negedge; noise drives a stray word while busy (R9)
    task automatic do_cmd(input logic [3:0] op, input int len, input logic [1:0] err,
                          input int gap, input int dly, input bit noise);
        bit   shrt = (len < mlen(op));
        bit   back = is_back(op) && !shrt;
        string t = tag_of(op, len, err);
        logic [15:0] e0 = exp_w0(op, len, err);
        tx_q.delete(); w_q.delete(); pl_q.delete();
        start_cnt = 0;
        send_word({op, 12'(len)}, gap);
        if ((shrt || (!is_back(op) && len == 1)) && gap == 0) begin
            #2;
            chk({t, " immediate tx_valid"}, 16'(tx_valid), 16'd1);
            chk({t, " immediate word"}, tx_data, e0);
            @(negedge clk);
        end
        if (!shrt) begin
            for (int i = 0; i < len - 1; i++) begin
                logic [15:0] p = 16'($urandom);
                pl_q.push_back(p);
                send_word(p, gap);
            end
        end
        if (back) begin
            for (int g = 0; g < 20 && start_cnt == 0; g++) @(negedge clk);
            if (noise) send_word(16'h0001, 0);
            repeat (dly) @(negedge clk);
            be_done = 1'b1;
            be_err  = err;
            @(negedge clk);
            be_done = 1'b0;
            if (noise) send_word(16'h0001, 0);
        end
        repeat (5) @(negedge clk);
        chk({t, " response count"}, 16'(tx_q.size()), 16'd2);
        if (tx_q.size() >= 2) begin
            chk({t, " status word"}, tx_q[0], e0);
            chk({t, " length word"}, tx_q[1], 16'h0002);
        end
        chk("R4 start count", 16'(start_cnt), back ? 16'd1 : 16'd0);
        if (back) chk("R4 start opcode", 16'(start_op), 16'(op));
        chk("R4 forwarded count", 16'(w_q.size()), back ? 16'(len - 1) : 16'd0);
        if (back && w_q.size() == pl_q.size())
            foreach (w_q[k]) chk("R4 forwarded word", w_q[k], pl_q[k]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        chk("R1 tx_valid in reset", 16'(tx_valid), 16'd0);
        chk("R1 be_start in reset", 16'(be_start), 16'd0);
        chk("R1 be_wvalid in reset", 16'(be_wvalid), 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 tx_valid after reset", 16'(tx_valid), 16'd0);
        chk("R1 be_start after reset", 16'(be_start), 16'd0);

        do_cmd(4'h0, 1, 2'd0, 0, 0, 0);   // R2
        do_cmd(4'h0, 3, 2'd0, 0, 0, 0);   // R2 with ignored payload
        do_cmd(4'hB, 1, 2'd0, 0, 0, 0);   // R3
        do_cmd(4'hD, 4, 2'd0, 0, 2, 0);   // R4 R5
        do_cmd(4'hD, 4, 2'd1, 0, 0, 0);   // R6
        do_cmd(4'h5, 3, 2'd2, 1, 3, 0);   // R6
        do_cmd(4'h4, 2, 2'd3, 0, 1, 0);   // R6
        do_cmd(4'h7, 3, 2'd0, 0, 0, 0);   // R7
        do_cmd(4'hF, 1, 2'd0, 0, 0, 0);   // R7
        do_cmd(4'hD, 2, 2'd0, 0, 0, 0);   // R8
        do_cmd(4'h0, 0, 2'd0, 0, 0, 0);   // R8 zero length
        do_cmd(4'h0, 1, 2'd0, 0, 0, 0);   // R8 next word parsed as header
        do_cmd(4'h5, 3, 2'd0, 0, 4, 1);   // R9 stray words while busy
        do_cmd(4'hD, 4, 2'd0, 60, 0, 0);  // R10 long gaps

        // R11: done strobe with nothing outstanding
        tx_q.delete();
        be_done = 1'b1; be_err = 2'd1;
        @(negedge clk);
        be_done = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 no response on stray done", 16'(tx_q.size()), 16'd0);
        do_cmd(4'hB, 1, 2'd0, 0, 0, 0);

        for (int n = 0; n < 60; n++) begin
            logic [3:0] op = 4'($urandom_range(0, 15));
            int len = int'($urandom_range(0, 6));
            logic [1:0] err = 2'($urandom_range(0, 3));
            do_cmd(op, len, err, int'($urandom_range(0, 2)), int'($urandom_range(0, 5)),
                   bit'($urandom_range(0, 1)));
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule